// File: doc/BRIEF.md
# Serial Peripheral Interface Frame Master with Programmable Select Timing

This block is the master side of a four-wire serial peripheral link. It accepts one word from its host over a valid/ready port and sends that word as one frame of 4 to 16 bits on the data-out line. While it sends, it collects a word of the same length from the data-in line. For each frame it drives the chip select low and waits a programmed lead time before the first serial clock edge. After the last edge it waits a programmed trail time and then releases the select. It then keeps the select high for a programmed minimum idle time before it will accept another word.

The host sets clock polarity, clock phase, bit order, frame length, the serial clock half-period and the three select delays. It does this through configuration inputs that the block samples once, when it accepts a word. The received word appears on the host side with a one-cycle valid pulse, and a wrapping counter of received words advances at the same time. The pulse comes on the last sampling edge of the frame. With phase 0 that is the next-to-last edge. With phase 1 it is the final edge.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, tx_ready is 1, rx_valid is 0 and rx_count is 0.
- R2: A word is accepted on a clock edge where tx_valid and tx_ready are both 1. spi_cs_n goes low at that same edge. tx_ready stays 0 for as long as spi_cs_n is low and during the idle gap that follows.
- R3: The first serial clock edge comes max(cfg_lead,1) system cycles after spi_cs_n falls.
- R4: A frame of N bits makes exactly 2N serial clock edges, spaced max(cfg_half_period,1) system cycles apart.
- R5: spi_cs_n rises max(cfg_trail,1) system cycles after the last serial clock edge.
- R6: tx_ready returns to 1 max(cfg_gap,1) system cycles after spi_cs_n rises.
- R7: spi_sclk rests at cfg_cpol (0 means low, 1 means high) whenever no frame is being clocked. It changes only while spi_cs_n is low.
- R8: With cfg_cpha = 0, the first data bit is on spi_mosi at the moment spi_cs_n falls. Data changes on even-numbered edges and is sampled on odd-numbered edges.
- R9: With cfg_cpha = 1, data changes on odd-numbered edges and is sampled on even-numbered edges.
- R10: With cfg_lsb_first = 0, bit N-1 of the word goes first on both lines. With cfg_lsb_first = 1, bit 0 goes first. The frame uses the low N bits of tx_data, and rx_data bits N and above read 0.
- R11: rx_valid is a one-cycle pulse carrying the full received word on rx_data. It rises at the edge that produces serial edge 2N-1 when cfg_cpha = 0, or serial edge 2N when cfg_cpha = 1. rx_count increments by 1 with each pulse.
- R12: The configuration inputs are sampled only when a word is accepted. Changing them during a frame does not change that frame's timing, mode or length.
- R13: The frame length N is cfg_frame_bits, clamped to the range 4 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on odd edges, 1 samples on even edges |
| cfg_lsb_first | input | 1 | Bit order: 0 sends MSB first, 1 sends LSB first |
| cfg_frame_bits | input | 5 | Frame length in bits, clamped to 4..16 |
| cfg_half_period | input | 8 | Serial clock half-period in system cycles |
| cfg_lead | input | 8 | Select-to-first-edge delay in system cycles |
| cfg_trail | input | 8 | Last-edge-to-deselect delay in system cycles |
| cfg_gap | input | 8 | Minimum deselected time in system cycles |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Block can accept a word |
| tx_data | input | 16 | Word to send |
| rx_valid | output | 1 | One-cycle pulse: received word is valid |
| rx_data | output | 16 | Received word |
| rx_count | output | 8 | Wrapping count of received words |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The embedded properties watch on every cycle that the select stays low through the lead, clock and trail phases. They also check that the host cannot hand over a word while the select is low, that the serial clock parks at the sampled polarity and moves only under select, that the edge count never passes 2N, and that each received-word pulse lasts a single cycle. Only the directed frames can show the exact spacing of the lead, half-period, trail and gap delays, together with the floor of one cycle for zero settings. The same holds for the bit order and phase seen by a model slave, the cycle in which the received word is reported, the frame-length clamp, and that configuration changes made during a frame are ignored.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_CLK   = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/spi_dly_timer.sv
// Down-counter used for every programmed interval. A loaded value v gives an
// interval of max(v,1) cycles before expire is seen.
module spi_dly_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          expire
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q > DW'(1)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q <= DW'(1));

endmodule

// File: rtl/spi_seq_ctrl.sv
// Frame sequencer: select, lead, clocking, trail and idle gap.
module spi_seq_ctrl
  import spi_master_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 5,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] lead_in,
  input  logic          cpol_in,
  input  logic          cpol_q,
  input  logic [DW-1:0] half_q,
  input  logic [DW-1:0] trail_q,
  input  logic [DW-1:0] gap_q,
  input  logic [BW-1:0] nbits_q,
  output logic          edge_fire,
  output logic [EW-1:0] edge_cnt,
  output logic          idle,
  output logic          sclk,
  output logic          cs_n
);

  seq_state_e    state_q, state_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic          sclk_q, sclk_d;
  logic          cs_q, cs_d;
  logic          tmr_load;
  logic [DW-1:0] tmr_val;
  logic          tmr_exp;
  logic [EW-1:0] two_n;

  assign two_n = {nbits_q, 1'b0};

  spi_dly_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_exp)
  );

  always_comb begin
    state_d   = state_q;
    ecnt_d    = ecnt_q;
    sclk_d    = sclk_q;
    cs_d      = cs_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    edge_fire = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_LEAD;
          tmr_load = 1'b1;
          tmr_val  = lead_in;
          cs_d     = 1'b0;
          sclk_d   = cpol_in;
          ecnt_d   = '0;
        end
      end
      ST_LEAD: begin
        if (tmr_exp) begin
          edge_fire = 1'b1;
          state_d   = ST_CLK;
          tmr_load  = 1'b1;
          tmr_val   = half_q;
        end
      end
      ST_CLK: begin
        if (tmr_exp) begin
          edge_fire = 1'b1;
          tmr_load  = 1'b1;
          if (ecnt_q == two_n - 1'b1) begin
            state_d = ST_TRAIL;
            tmr_val = trail_q;
          end else begin
            tmr_val = half_q;
          end
        end
      end
      ST_TRAIL: begin
        if (tmr_exp) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = gap_q;
          cs_d     = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (edge_fire) begin
      sclk_d = ~sclk_q;
      ecnt_d = ecnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
    end
  end

  assign edge_cnt = ecnt_q;
  assign idle     = (state_q == ST_IDLE);
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD || state_q == ST_CLK || state_q == ST_TRAIL) |-> !cs_q); // R2
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (sclk_q == cpol_q)); // R7
  AST_SCLK_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != $past(sclk_q)) |-> !cs_q); // R7
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_q <= two_n); // R4

endmodule

// File: rtl/spi_bit_engine.sv
// Data path: picks the outgoing bit from the edge count and assembles the
// incoming word on sampling edges.
module spi_bit_engine #(
  parameter int DATA_W = 16,
  parameter int BW     = 5,
  parameter int EW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              edge_fire,
  input  logic [EW-1:0]     edge_cnt,
  input  logic              cpha_q,
  input  logic              lsb_q,
  input  logic [BW-1:0]     nbits_q,
  input  logic              miso,
  output logic              mosi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] txbuf_q, txbuf_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              rxv_q, rxv_d;
  logic [EW-1:0]     em1, e_new, two_n;
  logic [BW-1:0]     last_idx, k_out, p_out, k_in, p_in;
  logic              smp;

  assign two_n    = {nbits_q, 1'b0};
  assign last_idx = nbits_q - 1'b1;

  // Outgoing bit position
  always_comb begin
    em1   = edge_cnt - 1'b1;
    k_out = cpha_q ? ((edge_cnt == '0) ? '0 : BW'(em1 >> 1)) : BW'(edge_cnt >> 1);
    if (k_out > last_idx) begin
      k_out = last_idx;
    end
    p_out = lsb_q ? k_out : (last_idx - k_out);
    mosi  = |(txbuf_q & (DATA_W'(1) << p_out));
  end

  // Incoming bit position and completion
  always_comb begin
    e_new   = edge_cnt + 1'b1;
    smp     = edge_fire && (e_new[0] ^ cpha_q);
    k_in    = BW'(edge_cnt >> 1);
    p_in    = lsb_q ? k_in : (last_idx - k_in);
    txbuf_d = start ? tx_data : txbuf_q;
    rxbuf_d = rxbuf_q;
    if (start) begin
      rxbuf_d = '0;
    end else if (smp) begin
      rxbuf_d = (rxbuf_q & ~(DATA_W'(1) << p_in)) | (DATA_W'(miso) << p_in);
    end
    rxv_d = smp && (e_new == (two_n - EW'(!cpha_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q <= '0;
      rxbuf_q <= '0;
      rxv_q   <= 1'b0;
    end else begin
      txbuf_q <= txbuf_d;
      rxbuf_q <= rxbuf_d;
      rxv_q   <= rxv_d;
    end
  end

  assign rx_valid = rxv_q;
  assign rx_data  = rxbuf_q;

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q); // R11

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 4,
  parameter int DW       = 8,
  parameter int RXC_W    = 8,
  parameter int BW       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [BW-1:0]     cfg_frame_bits,
  input  logic [DW-1:0]     cfg_half_period,
  input  logic [DW-1:0]     cfg_lead,
  input  logic [DW-1:0]     cfg_trail,
  input  logic [DW-1:0]     cfg_gap,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic [RXC_W-1:0]  rx_count,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int EW = BW + 1;

  logic              start;
  logic              idle;
  logic              edge_fire;
  logic [EW-1:0]     edge_cnt;
  logic [BW-1:0]     nbits_in;
  logic              cpol_q, cpha_q, lsb_q;
  logic              cpol_d, cpha_d, lsb_d;
  logic [BW-1:0]     nbits_q, nbits_d;
  logic [DW-1:0]     half_q, trail_q, gap_q;
  logic [DW-1:0]     half_d, trail_d, gap_d;
  logic [RXC_W-1:0]  rxc_q, rxc_d;

  assign tx_ready = idle;
  assign start    = tx_valid && idle;

  always_comb begin
    if (cfg_frame_bits < BW'(MIN_BITS)) begin
      nbits_in = BW'(MIN_BITS);
    end else if (cfg_frame_bits > BW'(DATA_W)) begin
      nbits_in = BW'(DATA_W);
    end else begin
      nbits_in = cfg_frame_bits;
    end
  end

  // Configuration capture at acceptance
  always_comb begin
    cpol_d  = start ? cfg_cpol        : cpol_q;
    cpha_d  = start ? cfg_cpha        : cpha_q;
    lsb_d   = start ? cfg_lsb_first   : lsb_q;
    nbits_d = start ? nbits_in        : nbits_q;
    half_d  = start ? cfg_half_period : half_q;
    trail_d = start ? cfg_trail       : trail_q;
    gap_d   = start ? cfg_gap         : gap_q;
    rxc_d   = rx_valid ? (rxc_q + 1'b1) : rxc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      nbits_q <= BW'(MIN_BITS);
      half_q  <= '0;
      trail_q <= '0;
      gap_q   <= '0;
      rxc_q   <= '0;
    end else begin
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      lsb_q   <= lsb_d;
      nbits_q <= nbits_d;
      half_q  <= half_d;
      trail_q <= trail_d;
      gap_q   <= gap_d;
      rxc_q   <= rxc_d;
    end
  end

  assign rx_count = rxc_q;

  spi_seq_ctrl #(.DW(DW), .BW(BW), .EW(EW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lead_in   (cfg_lead),
    .cpol_in   (cfg_cpol),
    .cpol_q    (cpol_q),
    .half_q    (half_q),
    .trail_q   (trail_q),
    .gap_q     (gap_q),
    .nbits_q   (nbits_q),
    .edge_fire (edge_fire),
    .edge_cnt  (edge_cnt),
    .idle      (idle),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n)
  );

  spi_bit_engine #(.DATA_W(DATA_W), .BW(BW), .EW(EW)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_data   (tx_data),
    .edge_fire (edge_fire),
    .edge_cnt  (edge_cnt),
    .cpha_q    (cpha_q),
    .lsb_q     (lsb_q),
    .nbits_q   (nbits_q),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

  AST_NO_ACCEPT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !tx_ready); // R2
  AST_RX_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !spi_cs_n); // R11

endmodule

// File: tb/spi_frame_master_bench.sv
module spi_frame_master_bench;
  localparam int DATA_W = 16;
  localparam int DW     = 8;
  localparam int BW     = 5;
  localparam int RXC_W  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [BW-1:0] cfg_frame_bits;
  logic [DW-1:0] cfg_half_period, cfg_lead, cfg_trail, cfg_gap;
  logic tx_valid, tx_ready;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic rx_valid;
  logic [RXC_W-1:0] rx_count;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  spi_frame_master u_spi_frame_master (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_frame_bits(cfg_frame_bits),
    .cfg_half_period(cfg_half_period), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .cfg_gap(cfg_gap), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_count(rx_count),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int spos(input int k, input int n, input bit lsb);
    return lsb ? k : (n - 1 - k);
  endfunction

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Model slave and timing monitor
  bit s_cpha, s_lsb;
  int s_n;
  logic [DATA_W-1:0] s_word, s_rx, rx_seen;
  int s_edges, t_csfall, t_first, t_last, t_csrise, t_ready, t_rxv, rxv_cnt;
  logic sclk_at_fall, mosi_at_fall, sclk_at_rise;
  bit frame_done;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_ready = 1'b1;

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      t_csfall = cyc; sclk_at_fall = spi_sclk; mosi_at_fall = spi_mosi;
      s_edges = 0; s_rx = '0;
      if (!s_cpha) spi_miso = s_word[spos(0, s_n, s_lsb)];
    end
    if (!prev_cs && !spi_cs_n && (spi_sclk != prev_sclk)) begin
      s_edges++;
      if (s_edges == 1) t_first = cyc;
      t_last = cyc;
      if (((s_edges % 2) == 1) != s_cpha) begin
        s_rx[spos((s_edges - 1) / 2, s_n, s_lsb)] = spi_mosi;
      end else begin
        int ko;
        ko = s_cpha ? (s_edges - 1) / 2 : s_edges / 2;
        if (ko < s_n) spi_miso = s_word[spos(ko, s_n, s_lsb)];
      end
    end
    if (!prev_cs && spi_cs_n) begin
      t_csrise = cyc; sclk_at_rise = spi_sclk;
    end
    if (!prev_ready && tx_ready) begin
      t_ready = cyc; frame_done = 1'b1;
    end
    if (rx_valid) begin
      t_rxv = cyc; rxv_cnt++; rx_seen = rx_data;
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_ready = tx_ready;
  end

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=frame completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // One frame with full checking; configuration inputs are scrambled after
  // acceptance so every frame also exercises R12.
  task automatic run_frame(input string name, input bit cpol, input bit cpha, input bit lsb,
                           input int fbits, input int h, input int l, input int t, input int g,
                           input logic [DATA_W-1:0] tx, input logic [DATA_W-1:0] sw);
    int n, t0, cnt0, exp_rxv;
    logic [DATA_W-1:0] mask;
    n = (fbits < 4) ? 4 : (fbits > 16) ? 16 : fbits;
    mask = DATA_W'((32'd1 << n) - 1);
    s_cpha = cpha; s_lsb = lsb; s_n = n; s_word = sw;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_frame_bits = BW'(fbits);
    cfg_half_period = DW'(h); cfg_lead = DW'(l); cfg_trail = DW'(t); cfg_gap = DW'(g);
    tx_data = tx;
    while (!tx_ready) @(negedge clk);
    frame_done = 1'b0; rxv_cnt = 0; cnt0 = int'(rx_count);
    tx_valid = 1'b1;
    @(negedge clk);
    t0 = cyc;
    tx_valid = 1'b0;
    cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_lsb_first = ~lsb; cfg_frame_bits = 5'd7;
    cfg_half_period = DW'(h + 5); cfg_lead = DW'(l + 3); cfg_trail = DW'(t + 4);
    cfg_gap = DW'(g + 6); tx_data = ~tx;
    check_eq({name, " R2 ready low after accept"}, int'(tx_ready), 0);
    while (!frame_done) @(negedge clk);
    check_eq({name, " R2 select falls at accept"}, t_csfall, t0);
    check_eq({name, " R7 sclk idle at select"}, int'(sclk_at_fall), int'(cpol));
    check_eq({name, " R7 sclk idle at deselect"}, int'(sclk_at_rise), int'(cpol));
    if (!cpha)
      check_eq({name, " R8 first bit at select"}, int'(mosi_at_fall), int'(tx[spos(0, n, lsb)]));
    check_eq({name, " R3 lead R12"}, t_first - t0, mx1(l));
    check_eq({name, " R4 R13 edge count"}, s_edges, 2 * n);
    check_eq({name, " R4 R12 edge span"}, t_last - t_first, (2 * n - 1) * mx1(h));
    check_eq({name, " R5 trail"}, t_csrise - t_last, mx1(t));
    check_eq({name, " R6 gap"}, t_ready - t_csrise, mx1(g));
    exp_rxv = cpha ? t_last : (t_last - mx1(h));
    check_eq({name, " R11 single pulse"}, rxv_cnt, 1);
    check_eq({name, " R11 pulse timing"}, t_rxv, exp_rxv);
    check_eq({name, " R11 counter"}, int'(rx_count), (cnt0 + 1) % 256);
    check_eq({name, " R10 R9 R8 received word"}, int'(rx_seen), int'(sw & mask));
    check_eq({name, " R10 R9 R8 slave word"}, int'(s_rx), int'(tx & mask));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_frame_bits = 5'd8;
    cfg_half_period = '0; cfg_lead = '0; cfg_trail = '0; cfg_gap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 cs_n", int'(spi_cs_n), 1);
    check_eq("R1 sclk", int'(spi_sclk), 0);
    check_eq("R1 tx_ready", int'(tx_ready), 1);
    check_eq("R1 rx_valid", int'(rx_valid), 0);
    check_eq("R1 rx_count", int'(rx_count), 0);
  endtask

  task automatic t_mode0;  run_frame("mode0", 0, 0, 0, 8, 2, 3, 2, 4, 16'h00A5, 16'h003C); endtask
  task automatic t_mode3;  run_frame("mode3", 1, 1, 1, 12, 3, 1, 5, 2, 16'h0B4D, 16'h0712); endtask
  task automatic t_mode1;  run_frame("mode1", 0, 1, 0, 16, 1, 2, 1, 1, 16'hBEEF, 16'h1234); endtask
  task automatic t_mode2;  run_frame("mode2", 1, 0, 1, 5, 4, 6, 3, 7, 16'h0013, 16'h000A); endtask
  task automatic t_zero;   run_frame("zero", 0, 0, 1, 4, 0, 0, 0, 0, 16'h0009, 16'h0006); endtask
  task automatic t_clamp;
    run_frame("clamp_low R13", 1, 1, 0, 2, 2, 2, 2, 2, 16'hFFF5, 16'hFFFA);
    run_frame("clamp_high R13", 0, 0, 0, 31, 1, 1, 1, 1, 16'hC3A1, 16'h5E7F);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode3();
    t_mode1();
    t_mode2();
    t_zero();
    t_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule